// File: doc/BRIEF.md
# Single-Channel Register-Programmed DMA Engine

This block moves data for one DMA channel. Software uses a small word-indexed register slave to load a source address, a destination address, a cycle count and a control word. Setting the enable bit starts the engine. Each beat reads one item from the source side over a simple master port and writes the captured data to the destination side. Both addresses move by their own signed step after every beat. A cycle is one beat, or a group of four beats in burst mode. The count register counts down, one per completed cycle.

A cycle can be paced by a request/grant handshake. A nonzero line number for a side makes each cycle wait for that request input. After the cycle's data has moved, the matching grant output pulses. The engine reports completion and bus errors in status bits. These bits can be cleared without disturbing other fields. A level interrupt follows the status bits through their enables.

Top module: `dma_chan_engine`

## Requirements
- R1: Register index 0 (byte offset 0) holds the source address, index 1 (offset 4) the destination address, index 2 (offset 8) the cycle count and index 3 (offset 12) the control word. The count keeps only its low 24 bits and reads zeros above them. Every register reads zero after reset.
- R2: Control bits are as follows. Bit 0 is enable, bit 1 finish status, bit 2 finish interrupt enable, bit 3 burst mode, bit 4 error status and bit 5 error interrupt enable. Bits 6 and 7 select the bus type for the source and destination side (1 = system bus), and `m_sys_bus_o` shows the bit of the side being accessed. Bits 10:8 hold the source step code and bits 14:12 the destination step code. Bits 27:24 hold the source request line and bits 19:16 the destination request line. Bits 21:20 hold the transfer width, which `m_size_o` shows (0 word, 1 half-word, 2 byte).
- R3: Each beat is a read at the current source address, then a write of the read data to the current destination address. A request on the master port keeps its valid, direction and address until `m_ready_i` is high.
- R4: After each accepted beat, each side's address changes by its step. The step codes are: 000 and 100 none, 001 +1, 010 +2, 011 +4, 101 -1, 110 -2, 111 -4. In burst mode the magnitude is four times larger. The address registers read back the stepped values.
- R5: A cycle is four beats in burst mode and one beat otherwise.
- R6: The count drops by one after each completed cycle, and a read shows the cycles still outstanding. When the count reaches zero the engine clears enable and sets finish status. Enabling with a count of zero finishes with no master access.
- R7: When a side's request line number is nonzero, a cycle starts only while that request input is high. If both sides have nonzero lines, both inputs must be high. Line 0 means no waiting.
- R8: When a cycle's last write is accepted, every nonzero selected line's grant output pulses high for exactly one clock. No other grant output is ever raised.
- R9: A master access that completes with `m_err_i` high sets error status, clears enable and ends the transfer. Finish status is not set, the count is not decremented, and no further access is made.
- R10: A control write clears a status bit where it writes 0 and leaves the bit unchanged where it writes 1. A status event in the same clock wins over the write.
- R11: `irq_o` is high while (finish status and finish interrupt enable) or (error status and error interrupt enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_idx_i` |
| m_valid_o | output | 1 | Master access request |
| m_write_o | output | 1 | 1 = write to destination, 0 = read from source |
| m_addr_o | output | ADDR_W | Master byte address |
| m_size_o | output | 2 | Transfer width code |
| m_sys_bus_o | output | 1 | Bus type of the side being accessed |
| m_wdata_o | output | DATA_W | Write data |
| m_rdata_i | input | DATA_W | Read data |
| m_ready_i | input | 1 | Access accepted this clock |
| m_err_i | input | 1 | Accepted access ended in error |
| req_i | input | NLINES | Request inputs, indexed by line number |
| grant_o | output | NLINES | Grant pulses, indexed by line number |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the engine with its default parameters: sixteen request lines, four-beat bursts, a 24-bit count and 32-bit addresses and data. With these values the bench can run every pairing of the eight source and eight destination step codes in single-beat mode. It also runs each signed step in burst mode, and it pulls non-adjacent line numbers from both handshake fields. Small cycle counts keep each transfer short, so the bench can compute every beat's address and data arithmetically. It also covers the stall, readback, error and zero-count cases.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   // control word bit positions; software and neighbours decode these
   localparam int CTL_EN      = 0;
   localparam int CTL_FIN     = 1;
   localparam int CTL_FIN_IE  = 2;
   localparam int CTL_BURST   = 3;
   localparam int CTL_ERR     = 4;
   localparam int CTL_ERR_IE  = 5;
   localparam int CTL_SRC_SYS = 6;
   localparam int CTL_DST_SYS = 7;
   localparam int SRC_STEP_LO = 8;
   localparam int DST_STEP_LO = 12;
   localparam int DST_LINE_LO = 16;
   localparam int WIDTH_LO    = 20;
   localparam int SRC_LINE_LO = 24;
   localparam int LINE_W      = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RD,
      ST_WR,
      ST_GRANT
   } eng_state_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int ADDR_W      = 32,
   parameter int BURST_SCALE = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [2:0]        code_i,
   input  logic              burst_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] mag;
   logic [ADDR_W-1:0] scaled;

   always_comb begin
      case (code_i[1:0])
         2'd1:    mag = ADDR_W'(1);
         2'd2:    mag = ADDR_W'(2);
         2'd3:    mag = ADDR_W'(4);
         default: mag = '0;
      endcase
   end

   generate
      if (BURST_SCALE == 1) begin : g_flat
         assign scaled = mag;
      end else begin : g_scaled
         assign scaled = burst_i ? mag * ADDR_W'(BURST_SCALE) : mag;
      end
   endgenerate

   assign addr_o = code_i[2] ? addr_i - scaled : addr_i + scaled;
endmodule

// File: rtl/dma_req_pacer.sv
module dma_req_pacer #(
   parameter int NLINES = 16,
   parameter int LINE_W = 4
) (
   input  logic [NLINES-1:0] req_i,
   input  logic [LINE_W-1:0] src_line_i,
   input  logic [LINE_W-1:0] dst_line_i,
   input  logic              grant_pulse_i,
   output logic              ok_o,
   output logic [NLINES-1:0] grant_o
);
   logic [NLINES-1:0] hit_s;
   logic [NLINES-1:0] hit_d;

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         if (i == 0) begin : g_free
            assign hit_s[i]   = 1'b0;
            assign hit_d[i]   = 1'b0;
            assign grant_o[i] = 1'b0;
         end else begin : g_num
            assign hit_s[i]   = (src_line_i == LINE_W'(i)) && req_i[i];
            assign hit_d[i]   = (dst_line_i == LINE_W'(i)) && req_i[i];
            assign grant_o[i] = grant_pulse_i &&
                                ((src_line_i == LINE_W'(i)) || (dst_line_i == LINE_W'(i)));
         end
      end
   endgenerate

   assign ok_o = ((src_line_i == '0) || (|hit_s)) && ((dst_line_i == '0) || (|hit_d));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 24,
   parameter int NLINES      = 16,
   parameter int BURST_BEATS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_idx_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic              m_valid_o,
   output logic              m_write_o,
   output logic [ADDR_W-1:0] m_addr_o,
   output logic [1:0]        m_size_o,
   output logic              m_sys_bus_o,
   output logic [DATA_W-1:0] m_wdata_o,
   input  logic [DATA_W-1:0] m_rdata_i,
   input  logic              m_ready_i,
   input  logic              m_err_i,
   input  logic [NLINES-1:0] req_i,
   output logic [NLINES-1:0] grant_o,
   output logic              irq_o
);
   localparam int BEAT_W = $clog2(BURST_BEATS);

   generate
      if (BURST_BEATS < 2 || NLINES < 2 || NLINES > 16 || CNT_W > 32 ||
          ADDR_W > 32 || DATA_W < 1) begin : g_bad_cfg
         $error("dma_chan_engine: unsupported parameter set");
      end
   endgenerate

   logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic [31:0]       ctl_q;
   logic [DATA_W-1:0] buf_q;
   logic [BEAT_W-1:0] beat_q, last_beat;
   eng_state_t        state;
   logic              pace_ok, fin_set, err_set, beat_ok;

   dma_addr_step #(.ADDR_W(ADDR_W), .BURST_SCALE(BURST_BEATS)) u_src_step (
      .addr_i(src_q), .code_i(ctl_q[SRC_STEP_LO +: 3]),
      .burst_i(ctl_q[CTL_BURST]), .addr_o(src_nxt));

   dma_addr_step #(.ADDR_W(ADDR_W), .BURST_SCALE(BURST_BEATS)) u_dst_step (
      .addr_i(dst_q), .code_i(ctl_q[DST_STEP_LO +: 3]),
      .burst_i(ctl_q[CTL_BURST]), .addr_o(dst_nxt));

   dma_req_pacer #(.NLINES(NLINES), .LINE_W(LINE_W)) u_pacer (
      .req_i(req_i), .src_line_i(ctl_q[SRC_LINE_LO +: LINE_W]),
      .dst_line_i(ctl_q[DST_LINE_LO +: LINE_W]),
      .grant_pulse_i(state == ST_GRANT), .ok_o(pace_ok), .grant_o(grant_o));

   assign last_beat = ctl_q[CTL_BURST] ? BEAT_W'(BURST_BEATS - 1) : '0;
   assign fin_set   = (state == ST_WAIT) && ctl_q[CTL_EN] && (cnt_q == '0);
   assign err_set   = m_valid_o && m_ready_i && m_err_i;
   assign beat_ok   = m_valid_o && m_ready_i && !m_err_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         ctl_q  <= '0;
         buf_q  <= '0;
         beat_q <= '0;
         state  <= ST_IDLE;
      end else begin
         // software side; engine updates below take precedence
         if (reg_wr_i) begin
            case (reg_idx_i)
               2'd0: src_q <= reg_wdata_i[ADDR_W-1:0];
               2'd1: dst_q <= reg_wdata_i[ADDR_W-1:0];
               2'd2: cnt_q <= reg_wdata_i[CNT_W-1:0];
               default: ctl_q <= {reg_wdata_i[31:5],
                                  reg_wdata_i[CTL_ERR] & ctl_q[CTL_ERR],
                                  reg_wdata_i[3:2],
                                  reg_wdata_i[CTL_FIN] & ctl_q[CTL_FIN],
                                  reg_wdata_i[CTL_EN]};
            endcase
         end
         case (state)
            ST_IDLE: if (ctl_q[CTL_EN]) state <= ST_WAIT;
            ST_WAIT: begin
               if (!ctl_q[CTL_EN]) begin
                  state <= ST_IDLE;
               end else if (fin_set) begin
                  ctl_q[CTL_EN]  <= 1'b0;
                  ctl_q[CTL_FIN] <= 1'b1;
                  state          <= ST_IDLE;
               end else if (pace_ok) begin
                  beat_q <= '0;
                  state  <= ST_RD;
               end
            end
            ST_RD: begin
               if (err_set) begin
                  ctl_q[CTL_EN]  <= 1'b0;
                  ctl_q[CTL_ERR] <= 1'b1;
                  state          <= ST_IDLE;
               end else if (beat_ok) begin
                  buf_q <= m_rdata_i;
                  src_q <= src_nxt;
                  state <= ST_WR;
               end
            end
            ST_WR: begin
               if (err_set) begin
                  ctl_q[CTL_EN]  <= 1'b0;
                  ctl_q[CTL_ERR] <= 1'b1;
                  state          <= ST_IDLE;
               end else if (beat_ok) begin
                  dst_q <= dst_nxt;
                  if (beat_q == last_beat) begin
                     cnt_q <= cnt_q - CNT_W'(1);
                     state <= ST_GRANT;
                  end else begin
                     beat_q <= beat_q + BEAT_W'(1);
                     state  <= ST_RD;
                  end
               end
            end
            ST_GRANT: state <= ST_WAIT;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (reg_idx_i)
         2'd0:    reg_rdata_o = 32'(src_q);
         2'd1:    reg_rdata_o = 32'(dst_q);
         2'd2:    reg_rdata_o = 32'(cnt_q);
         default: reg_rdata_o = ctl_q;
      endcase
   end

   assign m_valid_o   = (state == ST_RD) || (state == ST_WR);
   assign m_write_o   = (state == ST_WR);
   assign m_addr_o    = m_write_o ? dst_q : src_q;
   assign m_wdata_o   = buf_q;
   assign m_size_o    = ctl_q[WIDTH_LO +: 2];
   assign m_sys_bus_o = m_write_o ? ctl_q[CTL_DST_SYS] : ctl_q[CTL_SRC_SYS];
   assign irq_o       = (ctl_q[CTL_FIN] & ctl_q[CTL_FIN_IE]) |
                        (ctl_q[CTL_ERR] & ctl_q[CTL_ERR_IE]);

   // R3: a pending request holds its shape until accepted
   a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_addr_o) && $stable(m_write_o));

   // R6: finish status only appears with the count exhausted and enable dropped
   a_r6_finish_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q[CTL_FIN]) |-> (cnt_q == '0) && !ctl_q[CTL_EN]);

   // R8: grants only follow an accepted write
   a_r8_grant_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) |-> $past(m_write_o && m_ready_i && !m_err_i));

   // R9: an error leaves the engine stopped and the master port quiet
   a_r9_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q[CTL_ERR]) |-> !ctl_q[CTL_EN] && !m_valid_o);
endmodule

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
   localparam int NL = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        m_valid, m_write, m_sys_bus, m_ready, m_err, irq;
   logic [31:0] m_addr, m_wdata, m_rdata;
   logic [1:0]  m_size;
   logic [NL-1:0] req = '0;
   logic [NL-1:0] grant;

   always #10 clk = ~clk;

   dma_chan_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_idx_i(reg_idx),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .m_valid_o(m_valid),
      .m_write_o(m_write), .m_addr_o(m_addr), .m_size_o(m_size),
      .m_sys_bus_o(m_sys_bus), .m_wdata_o(m_wdata), .m_rdata_i(m_rdata),
      .m_ready_i(m_ready), .m_err_i(m_err), .req_i(req), .grant_o(grant),
      .irq_o(irq));

   int checks = 0;
   int errors = 0;
   int nwr = 0;
   int nrd = 0;
   int gcnt [NL];
   logic [31:0] wr_addr [64];
   logic [31:0] wr_data [64];
   logic err_arm = 1'b0;
   logic last_w_sys, last_r_sys;
   logic [1:0] last_w_size;
   logic [15:0] lfsr = 16'hACE1;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'h3C5A, a[15:0]};
   endfunction

   function automatic int step_of(input int code, input bit burst);
      int mag;
      mag = ((code & 3) == 0) ? 0 : (1 << ((code & 3) - 1));
      if (burst) mag = mag * 4;
      return ((code & 4) != 0) ? -mag : mag;
   endfunction

   task automatic check(input bit ok, input string rq, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // master responder and monitor, all at the falling edge
   initial begin
      m_ready = 1'b0; m_err = 1'b0; m_rdata = '0;
      for (int i = 0; i < NL; i++) gcnt[i] = 0;
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         m_ready = m_valid && (lfsr[0] | lfsr[1]);
         m_err   = 1'b0;
         m_rdata = pat(m_addr);
         if (m_valid && m_ready) begin
            if (err_arm) begin
               m_err = 1'b1;
               err_arm = 1'b0;
            end
            if (m_write) begin
               if (nwr < 64) begin
                  wr_addr[nwr] = m_addr;
                  wr_data[nwr] = m_wdata;
               end
               nwr++;
               last_w_sys  = m_sys_bus;
               last_w_size = m_size;
            end else begin
               nrd++;
               last_r_sys = m_sys_bus;
            end
         end
         for (int i = 0; i < NL; i++) if (grant[i]) gcnt[i]++;
      end
   end

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      report();
      $finish;
   end

   task automatic wr(input logic [1:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] idx, output logic [31:0] d);
      @(negedge clk);
      reg_idx = idx;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(input string rq);
      logic [31:0] c;
      for (int k = 0; k < 3000; k++) begin
         rd(2'd3, c);
         if (!c[0]) return;
      end
      check(1'b0, rq, c, 32'h0);
   endtask

   task automatic clear_counts();
      nwr = 0; nrd = 0;
      for (int i = 0; i < NL; i++) gcnt[i] = 0;
   endtask

   task automatic run_xfer(input logic [31:0] s0, input logic [31:0] d0,
                           input int n, input logic [31:0] ctl);
      int ss, ds, beats, nb;
      bit ok_a, ok_d;
      logic [31:0] v;
      ss = step_of(int'(ctl[10:8]), ctl[3]);
      ds = step_of(int'(ctl[14:12]), ctl[3]);
      beats = ctl[3] ? 4 : 1;
      nb = n * beats;
      clear_counts();
      wr(2'd0, s0); wr(2'd1, d0); wr(2'd2, 32'(n));
      wr(2'd3, ctl); wr(2'd3, ctl | 32'h1);
      wait_idle("R6 transfer end");
      check(nwr == nb, "R5 beats per transfer", 32'(nwr), 32'(nb));
      ok_a = 1'b1; ok_d = 1'b1;
      for (int k = 0; k < nb && k < 64; k++) begin
         if (wr_addr[k] !== d0 + 32'(k * ds)) ok_a = 1'b0;
         if (wr_data[k] !== pat(s0 + 32'(k * ss))) ok_d = 1'b0;
      end
      check(ok_a, "R4 destination addresses", wr_addr[0], d0);
      check(ok_d, "R3 data follows source reads", wr_data[0], pat(s0));
      rd(2'd0, v);
      check(v == s0 + 32'(nb * ss), "R4 source readback", v, s0 + 32'(nb * ss));
      rd(2'd1, v);
      check(v == d0 + 32'(nb * ds), "R4 destination readback", v, d0 + 32'(nb * ds));
      rd(2'd2, v);
      check(v == 32'h0, "R6 count at end", v, 32'h0);
      rd(2'd3, v);
      check(v[1:0] == 2'b10, "R6 finish set enable clear", {30'h0, v[1:0]}, 32'h2);
      #1 check(irq == ctl[2], "R11 finish interrupt", {31'h0, irq}, {31'h0, ctl[2]});
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] ctl;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 4; i++) begin
         rd(2'(i), v);
         check(v == 32'h0, "R1 reset register value", v, 32'h0);
      end
      check(!irq && !m_valid, "R1 reset outputs", {30'h0, irq, m_valid}, 32'h0);
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd2, v);
      check(v == 32'h00FF_FFFF, "R1 count width", v, 32'h00FF_FFFF);
      wr(2'd2, 32'h0);

      // R4 R5 sweep of all step code pairs, single-beat cycles
      for (int sc = 0; sc < 8; sc++) begin
         for (int dc = 0; dc < 8; dc++) begin
            ctl = 32'(sc) << 8 | 32'(dc) << 12 | (32'((sc + dc) % 2) << 2);
            run_xfer(32'h1000_0100 + 32'(sc * 16), 32'h2000_0800 + 32'(dc * 32), 2, ctl);
         end
      end

      // R5 burst mode with every signed magnitude
      for (int c = 1; c < 8; c++) begin
         if (c == 4) continue;
         ctl = 32'(c) << 8 | 32'((c + 3) % 8) << 12 | 32'h8 | 32'h4;
         run_xfer(32'h3000_4000, 32'h4000_8000, 3, ctl);
      end

      // R2 bus select and width outputs
      ctl = 32'h1 << 8 | 32'h1 << 12 | 32'h80 | 32'h1 << 20;
      run_xfer(32'h500, 32'h900, 1, ctl);
      check(last_w_sys == 1'b1 && last_r_sys == 1'b0, "R2 bus select per side",
            {30'h0, last_w_sys, last_r_sys}, 32'h2);
      check(last_w_size == 2'd1, "R2 width field", {30'h0, last_w_size}, 32'h1);

      // R6 zero count finishes without any access
      clear_counts();
      wr(2'd2, 32'h0);
      wr(2'd3, 32'h1);
      wait_idle("R6 zero count end");
      rd(2'd3, v);
      check(v[1] && (nrd + nwr) == 0, "R6 zero count", 32'(nrd + nwr), 32'h0);

      // R7 R8 numbered pacing: source line 5, destination line 9
      clear_counts();
      req = '0;
      ctl = 32'd5 << 24 | 32'd9 << 16 | 32'h3 << 8 | 32'h3 << 12;
      wr(2'd0, 32'h600); wr(2'd1, 32'hA00); wr(2'd2, 32'd3);
      wr(2'd3, ctl); wr(2'd3, ctl | 32'h1);
      repeat (20) @(negedge clk);
      check(nrd == 0, "R7 stall with no request", 32'(nrd), 32'h0);
      req[5] = 1'b1;
      repeat (20) @(negedge clk);
      check(nrd == 0, "R7 both requests needed", 32'(nrd), 32'h0);
      req[9] = 1'b1;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         #1;
         if (grant[9]) break;
      end
      req = '0;
      repeat (10) @(negedge clk);
      rd(2'd2, v);
      check(v == 32'd2, "R6 remaining count readback", v, 32'd2);
      check(nwr == 1, "R7 one cycle then stall", 32'(nwr), 32'h1);
      check(gcnt[5] == 1 && gcnt[9] == 1, "R8 single grant pulse",
            32'(gcnt[5] * 16 + gcnt[9]), 32'h11);
      req[5] = 1'b1; req[9] = 1'b1;
      wait_idle("R7 paced end");
      req = '0;
      v = 0;
      for (int i = 0; i < NL; i++) if (i != 5 && i != 9) v = v + 32'(gcnt[i]);
      check(gcnt[5] == 3 && gcnt[9] == 3 && v == 0, "R8 grant lines",
            32'(gcnt[5] * 16 + gcnt[9]), 32'h33);
      check(nwr == 3, "R7 paced beats", 32'(nwr), 32'h3);

      // R9 error: finish still set from the last transfer, kept by writing 1
      clear_counts();
      wr(2'd2, 32'd4);
      err_arm = 1'b1;
      wr(2'd3, 32'h20 | 32'h2 | 32'h1 << 8 | 32'h1 << 12 | 32'h1);
      wait_idle("R9 error end");
      repeat (10) @(negedge clk);
      rd(2'd3, v);
      check(v[4] == 1'b1 && v[0] == 1'b0, "R9 error status", {27'h0, v[4:0]}, 32'h12);
      check(v[1] == 1'b1, "R10 write 1 keeps finish", {31'h0, v[1]}, 32'h1);
      rd(2'd2, v);
      check(v == 32'd4, "R9 count untouched", v, 32'd4);
      check(nrd == 1 && nwr == 0, "R9 no access after error", 32'(nrd * 16 + nwr), 32'h10);
      #1 check(irq == 1'b1, "R11 error interrupt", {31'h0, irq}, 32'h1);

      // R10 clear finish while keeping error, then clear error
      wr(2'd3, 32'h20 | 32'h10);
      rd(2'd3, v);
      check(v[4] && !v[1], "R10 selective clear", {27'h0, v[4:0]}, 32'h10);
      #1 check(irq == 1'b1, "R11 irq follows error", {31'h0, irq}, 32'h1);
      wr(2'd3, 32'h20);
      rd(2'd3, v);
      check(!v[4], "R10 error cleared", {31'h0, v[4]}, 32'h0);
      #1 check(irq == 1'b0, "R11 irq drops", {31'h0, irq}, 32'h0);

      report();
      $finish;
   end
endmodule